// File: doc/BRIEF.md
# Selectable Ratio Synchronous Clock Divider

This block derives two related clocks from one input clock. The first output runs at half the input frequency. The second runs at one quarter or one sixth of the input frequency, and a select input picks the ratio. Both divider stages step on the same rising input edge, so every rising edge of the slower output coincides with a rising edge of the half-rate output. A one-period marker pulse flags each of those shared rising edges, so a downstream block can lock onto the common phase.

An active-low run enable gates both stages. It is captured on the falling input edge, which means the dividers only start or stop while the input clock is low. An asynchronous active-low reset clears both outputs and the marker. A new ratio selection is applied only at a shared rising edge, so the slow output never produces a period of irregular length.

Top module: `sync_clk_divider`

## Requirements
- R1: On every enabled rising edge of `clk_i`, `q_div2_o` inverts, which gives half the input frequency.
- R2: With the applied ratio select at 0, `q_div46_o` is high for 2 enabled edges and then low for 2. With the select at 1, it is high for 3 and then low for 3.
- R3: Every rising edge of `q_div46_o` falls on the same input edge as a rising edge of `q_div2_o`.
- R4: While the captured enable is high (disabled), rising edges leave `q_div2_o`, `q_div46_o` and `phase_o` unchanged.
- R5: `en_ni` is captured on the falling edge of `clk_i`. A change made after a falling edge has no effect on the next rising edge. It takes effect on the rising edge after the following falling edge.
- R6: `phase_o` goes high on the edge where both outputs rise together. It stays high for exactly one enabled input period and is low at all other times.
- R7: While `rst_ni` is low, all outputs are forced low at once, without waiting for a clock edge. After release, the first enabled rising edge drives both outputs high and asserts `phase_o`.
- R8: `divsel_i` is sampled only on a shared rising edge (0 selects divide by 4, 1 selects divide by 6). A change at any other time leaves the running period unchanged until the next shared rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_ni | input | 1 | Run enable, active low, captured on the falling edge |
| divsel_i | input | 1 | Ratio select: 0 gives divide by 4, 1 gives divide by 6 |
| q_div2_o | output | 1 | Half-rate output clock |
| q_div46_o | output | 1 | Quarter-rate or sixth-rate output clock |
| phase_o | output | 1 | Shared rising edge marker |

## Verification
A free-running divide-by-4 pattern fixes the basic period, duty cycle, alignment and marker timing. It is followed by a switch to divide-by-6 in the middle of a period, which separates a design that applies the select at once from one that waits for the shared rising edge. Stretches with the enable held off show whether the dividers hold their state or advance. Enable changes made just before and just after a falling edge show whether the enable is sampled on that edge or on the rising edge. A reset in the middle of a run, followed by the first enabled edge, tests the fixed restart phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic {
    SEL_QUARTER = 1'b0,
    SEL_SIXTH   = 1'b1
  } ratio_sel_e;
endpackage

// File: rtl/clkdiv_en_sync.sv
module clkdiv_en_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic adv_o
);
  logic en_q_n;

  // falling-edge capture: gating can only change while clk is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_n <= 1'b1;
    else         en_q_n <= en_ni;
  end

  assign adv_o = ~en_q_n;
endmodule

// File: rtl/clkdiv_half.sv
module clkdiv_half (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (adv_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio
  import clkdiv_pkg::*;
#(
  parameter int LO_HALF = 2,
  parameter int HI_HALF = 3,
  localparam int CNT_W  = $clog2(HI_HALF)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic divsel_i,
  output logic q_o,
  output logic rise_o
);
  ratio_sel_e       sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  function automatic logic [CNT_W-1:0] reload(input ratio_sel_e s);
    return (s == SEL_SIXTH) ? CNT_W'(HI_HALF - 1) : CNT_W'(LO_HALF - 1);
  endfunction

  assign at_end = (cnt_q == '0);
  assign rise_o = adv_i & at_end & ~q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= 1'b0;
      cnt_q <= '0;
      sel_q <= SEL_QUARTER;
    end else if (adv_i) begin
      if (at_end) begin
        q_o <= ~q_o;
        if (!q_o) begin
          // shared rising edge: only point where a new ratio is taken
          sel_q <= ratio_sel_e'(divsel_i);
          cnt_q <= reload(ratio_sel_e'(divsel_i));
        end else begin
          cnt_q <= reload(sel_q);
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic slow_rise_i,
  input  logic fast_q_i,
  output logic phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_o <= 1'b0;
    else if (adv_i) phase_o <= slow_rise_i & ~fast_q_i;
  end
endmodule

// File: rtl/sync_clk_divider.sv
module sync_clk_divider #(
  parameter int LO_HALF = 2,
  parameter int HI_HALF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  input  logic divsel_i,
  output logic q_div2_o,
  output logic q_div46_o,
  output logic phase_o
);
  logic adv;
  logic slow_rise;

  clkdiv_en_sync u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_ni (en_ni),
    .adv_o (adv)
  );

  clkdiv_half u_half (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .q_o   (q_div2_o)
  );

  clkdiv_ratio #(
    .LO_HALF(LO_HALF),
    .HI_HALF(HI_HALF)
  ) u_ratio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .divsel_i(divsel_i),
    .q_o     (q_div46_o),
    .rise_o  (slow_rise)
  );

  clkdiv_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .slow_rise_i(slow_rise),
    .fast_q_i   (q_div2_o),
    .phase_o    (phase_o)
  );
endmodule

// File: rtl/sync_clk_divider_chk.sv
module sync_clk_divider_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic adv,
  input logic q_div2_o,
  input logic q_div46_o,
  input logic phase_o
);
  p_div2_toggle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> (q_div2_o != $past(q_div2_o)));

  p_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_div46_o) |-> $rose(q_div2_o));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> ($stable(q_div2_o) && $stable(q_div46_o) && $stable(phase_o)));

  p_phase_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o) |-> ($rose(q_div2_o) && $rose(q_div46_o)));

  p_phase_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o && adv) |=> !phase_o);

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_r7: assert (!q_div2_o && !q_div46_o && !phase_o);
    end
  end
endmodule

bind sync_clk_divider sync_clk_divider_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .adv      (adv),
  .q_div2_o (q_div2_o),
  .q_div46_o(q_div46_o),
  .phase_o  (phase_o)
);

// File: tb/tb_sync_clk_divider.sv
module tb_sync_clk_divider;
  localparam int CLK_PERIOD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b1;
  logic divsel = 1'b0;
  logic q2, q46, ph;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic  q2;
    logic  q46;
    logic  ph;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  bit   started = 0;
  int   s = 0;
  int   h = 2;
  logic ph_m = 1'b0;
  logic en_prev = 1'b1;

  sync_clk_divider dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_ni    (en_n),
    .divsel_i (divsel),
    .q_div2_o (q2),
    .q_div46_o(q46),
    .phase_o  (ph)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic compare(input exp_t e);
    checks++;
    if (q2 !== e.q2 || q46 !== e.q46 || ph !== e.ph) begin
      fails++;
      $display("FAIL %s: got q2=%b q46=%b ph=%b, expected q2=%b q46=%b ph=%b",
               e.tag, q2, q46, ph, e.q2, e.q46, e.ph);
    end
  endtask

  // drive inputs for the next rising edge and predict its result
  task automatic step(input logic en_v, input logic sel_v, input bit late, input string tag);
    logic use_en;
    exp_t e;
    @(posedge clk);
    if (late) #(3 * CLK_PERIOD / 4);
    else      #(CLK_PERIOD / 4);
    en_n   = en_v;
    divsel = sel_v;
    use_en = late ? en_prev : en_v;
    en_prev = en_v;
    if (use_en == 1'b0) begin
      if (!started || s == 2 * h - 1) begin
        s = 0;
        h = sel_v ? 3 : 2;
        started = 1;
      end else begin
        s++;
      end
      ph_m = (s == 0);
    end
    e.q2  = started && (s % 2 == 0);
    e.q46 = started && (s < h);
    e.ph  = ph_m;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic run(input int n, input logic en_v, input logic sel_v, input string tag);
    for (int i = 0; i < n; i++) step(en_v, sel_v, 1'b0, tag);
  endtask

  task automatic do_reset();
    exp_t e;
    @(posedge clk);
    #(CLK_PERIOD / 4);
    en_n = 1'b1;
    en_prev = 1'b1;
    rst_n = 1'b0;
    #2;
    e.q2 = 1'b0; e.q46 = 1'b0; e.ph = 1'b0; e.tag = "R7 async reset";
    compare(e);
    repeat (2) @(posedge clk);
    #(CLK_PERIOD / 4);
    rst_n = 1'b1;
    started = 0; s = 0; h = 2; ph_m = 1'b0;
  endtask

  // monitor: compare each predicted result just after its edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD / 8);
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected end of stimulus");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(1'b0, 1'b0, 1'b0, "R7 first edge");
    run(15, 1'b0, 1'b0, "R1 R2 R3 R6 div4");
    run(4, 1'b1, 1'b0, "R4 hold");
    run(5, 1'b0, 1'b0, "R4 resume");
    run(20, 1'b0, 1'b1, "R8 switch to div6");
    step(1'b1, 1'b1, 1'b1, "R5 late disable");
    step(1'b1, 1'b1, 1'b0, "R5 disabled");
    step(1'b0, 1'b1, 1'b1, "R5 late enable");
    step(1'b0, 1'b1, 1'b0, "R5 enabled");
    run(8, 1'b0, 1'b1, "R2 div6");
    run(14, 1'b0, 1'b0, "R8 switch to div4");
    do_reset();
    step(1'b0, 1'b1, 1'b0, "R7 restart");
    run(8, 1'b0, 1'b1, "R7 R2 after restart");
    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule